// File: doc/BRIEF.md
# Byte-serial address port to parallel memory bridge

This block connects a host that reaches memory through a narrow byte port to an ordinary parallel memory device. On that port an address is never presented in parallel. The host loads it one byte at a time through the data lines, and the block keeps it in an internal counter. Each data read or data write then moves the counter on by one. The bridge turns every host data access into one memory cycle at the counter's address. It shows the access as pending on a ready line until the memory has had a programmable number of clock cycles.

The 16-bit counter holds a 3-bit bank in its top bits and a 13-bit offset below them. Stepping changes only the offset, which wraps inside its 8 KB window. A small sequencer decides whether an address write lands in the high or the low byte. Any data access sends it back to the high byte.

An address read returns the high byte and then moves the low byte up into the high position. The host bus numbers its bits in the opposite order to the memory bus, so every byte that crosses the bridge is mirrored.

Top module: `gport_bridge`

## Requirements
- R1: While `sel_n` is high, the block ignores `mode`, `dir` and `hd_i`. It keeps `hd_oe` low, `mcs_n` high and `rdy` low, and its address counter does not change.
- R2: An access starts in the first cycle in which `sel_n` is sampled low while the block is idle. `rdy` is high for exactly WAIT_CYC+1 cycles starting with that cycle. It then stays low until `sel_n` returns high. After reset `rdy` and `hd_oe` are low and `mcs_n` is high.
- R3: For any read access, `hd_oe` rises one cycle after `rdy` falls, and the byte on `hd_o` is valid from that cycle.
- R4: Two successive address writes (`mode`=1, `dir`=0) load the counter, first the high byte and then the low byte.
- R5: A data read (`mode`=0, `dir`=1) returns the memory byte at the counter address, and the offset then advances by one.
- R6: A data write (`mode`=0, `dir`=0) holds `mcs_n` low, `mrw` low and `md_oe` high for WAIT_CYC cycles, with `ma` equal to the counter and `md_o` carrying the byte. The offset then advances by one.
- R7: Address reads and address writes never assert `mcs_n` and never advance the counter.
- R8: Stepping wraps the 13-bit offset (bits 12..0) from 0x1FFF to 0x0000 and leaves bank bits 15..13 unchanged. For example, 0x3FFF is followed by 0x2000.
- R9: Every data access returns the address byte sequencer to "high byte next".
- R10: An address read (`mode`=1, `dir`=1) returns the counter's high byte and then copies the low byte into the high byte. From 0x1234 it returns 0x12, then 0x34.
- R11: Host bit i corresponds to memory bit 7-i for every byte in both directions. For example, host pattern 0x01 written as data appears on `md_o` as 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low port select |
| mode | input | 1 | 1 = address access, 0 = data access |
| dir | input | 1 | 1 = read, 0 = write |
| hd_i | input | 8 | Host data in (host bit order) |
| hd_o | output | 8 | Host data out (host bit order) |
| hd_oe | output | 1 | Host data bus drive enable |
| rdy | output | 1 | High while the access is pending |
| ma | output | 16 | Memory address |
| md_o | output | 8 | Memory write data |
| md_i | input | 8 | Memory read data |
| md_oe | output | 1 | Memory write data drive enable |
| mrw | output | 1 | Memory strobe, 1 = read, 0 = write |
| mcs_n | output | 1 | Active-low memory chip select |

## Verification
A data read captures the memory byte and steps the counter on the same clock edge. That edge also clears the byte sequencer. If the capture and the step are out of order, the host receives the byte one address ahead. The bench provokes this with back-to-back data reads, including a pair that crosses the 0x3FFF to 0x2000 wrap. It judges the result by comparing every returned byte with an address-derived pattern, and by reading the counter back through address reads. A half-loaded address followed by a data access then shows whether the sequencer clear took effect in that same cycle.

// File: rtl/gb_pkg.sv
package gb_pkg;
    parameter int BANK_W = 3;
    parameter int OFS_W  = 13;
    parameter int DW     = 8;
    localparam int AW    = BANK_W + OFS_W;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef struct packed {
        logic  is_addr;
        logic  is_read;
        byte_t wbyte;
    } req_t;

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} st_e;
endpackage

// File: rtl/gb_swap.sv
module gb_swap #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = a[W-1-i];
    end
endmodule

// File: rtl/gb_seq.sv
module gb_seq
    import gb_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    output logic start,
    output logic fin,
    output logic busy,
    output logic show,
    output logic rdy
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    st_e           st;
    logic [CW-1:0] cnt;
    logic          shown;

    assign start = (st == ST_IDLE) && !sel_n;
    assign busy  = (st == ST_BUSY);
    assign fin   = busy && (cnt == '0);
    assign rdy   = start || busy;
    assign show  = (st == ST_DONE) && shown;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            shown <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    shown <= 1'b0;
                    if (!sel_n) begin
                        st  <= ST_BUSY;
                        cnt <= CW'(WAIT_CYC - 1);
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0) st <= ST_DONE;
                    else           cnt <= cnt - 1'b1;
                end
                ST_DONE: begin
                    shown <= 1'b1;
                    if (sel_n) begin
                        st    <= ST_IDLE;
                        shown <= 1'b0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gb_addr.sv
module gb_addr
    import gb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  commit,
    input  req_t  req,
    output addr_t addr
);
    logic             lo_next;
    logic [OFS_W-1:0] ofs_inc;

    assign ofs_inc = addr[OFS_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            lo_next <= 1'b0;
        end else if (commit) begin
            if (req.is_addr) begin
                if (req.is_read) begin
                    addr[AW-1:DW] <= addr[DW-1:0];
                end else if (!lo_next) begin
                    addr[AW-1:DW] <= req.wbyte;
                    lo_next       <= 1'b1;
                end else begin
                    addr[DW-1:0]  <= req.wbyte;
                    lo_next       <= 1'b0;
                end
            end else begin
                addr    <= {addr[AW-1:OFS_W], ofs_inc};
                lo_next <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gport_bridge.sv
module gport_bridge
    import gb_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_n,
    input  logic          mode,
    input  logic          dir,
    input  logic [DW-1:0] hd_i,
    output logic [DW-1:0] hd_o,
    output logic          hd_oe,
    output logic          rdy,
    output logic [AW-1:0] ma,
    output logic [DW-1:0] md_o,
    input  logic [DW-1:0] md_i,
    output logic          md_oe,
    output logic          mrw,
    output logic          mcs_n
);
    logic  start_w, fin_w, busy_w, show_w;
    byte_t host_in_m, rbyte_q;
    req_t  req_q;
    addr_t addr_q;
    logic  mem_act;
    logic  req_is_addr, req_is_read;

    gb_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk(clk), .rst(rst), .sel_n(sel_n),
        .start(start_w), .fin(fin_w), .busy(busy_w), .show(show_w), .rdy(rdy)
    );

    gb_swap #(.W(DW)) u_swap_in  (.a(hd_i),    .y(host_in_m));
    gb_swap #(.W(DW)) u_swap_out (.a(rbyte_q), .y(hd_o));

    gb_addr u_addr (
        .clk(clk), .rst(rst), .commit(fin_w), .req(req_q), .addr(addr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            rbyte_q <= '0;
        end else begin
            if (start_w) req_q <= '{is_addr: mode, is_read: dir, wbyte: host_in_m};
            if (fin_w)   rbyte_q <= req_q.is_addr ? addr_q[AW-1:DW] : md_i;
        end
    end

    assign req_is_addr = req_q.is_addr;
    assign req_is_read = req_q.is_read;
    assign mem_act     = busy_w && !req_q.is_addr;
    assign mcs_n       = !mem_act;
    assign md_oe       = mem_act && !req_q.is_read;
    assign mrw         = !md_oe;
    assign md_o        = md_oe ? req_q.wbyte : '0;
    assign ma          = addr_q;
    assign hd_oe       = show_w && req_q.is_read && !sel_n;
endmodule

// File: rtl/gb_bridge_chk.sv
module gb_bridge_chk
    import gb_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  rdy,
    input logic  hd_oe,
    input logic  mcs_n,
    input logic  fin,
    input logic  is_addr,
    input logic  is_read,
    input addr_t addr
);
    // R7 / R6: memory only selected while the access is still pending
    p_mem_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
        !mcs_n |-> rdy);

    // R7: address reads leave the low byte alone
    p_addr_no_inc_r7: assert property (@(posedge clk) disable iff (rst)
        (fin && is_addr && is_read) |=> addr[DW-1:0] == $past(addr[DW-1:0]));

    // R8: bank bits untouched by data stepping
    p_bank_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (fin && !is_addr) |=> addr[AW-1:OFS_W] == $past(addr[AW-1:OFS_W]));

    // R5: offset advances by one per data access
    p_offset_step_r5: assert property (@(posedge clk) disable iff (rst)
        (fin && !is_addr) |=> addr[OFS_W-1:0] == OFS_W'($past(addr[OFS_W-1:0]) + 1'b1));

    // R3: data driven only after ready already fell
    p_data_after_rdy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hd_oe) |-> !$past(rdy));

    // R2: never pending while host bus is driven
    p_rdy_low_shown_r2: assert property (@(posedge clk) disable iff (rst)
        hd_oe |-> !rdy);
endmodule

bind gport_bridge gb_bridge_chk u_chk (
    .clk(clk), .rst(rst), .rdy(rdy), .hd_oe(hd_oe), .mcs_n(mcs_n),
    .fin(fin_w), .is_addr(req_is_addr), .is_read(req_is_read), .addr(addr_q)
);

// File: tb/gport_bridge_tb.sv
module gport_bridge_tb_top;
    localparam int WAIT_CYC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, mode = 1'b0, dir = 1'b0;
    logic [7:0]  hd_i = 8'h00;
    logic [7:0]  hd_o, md_o, md_i;
    logic        hd_oe, rdy, md_oe, mrw, mcs_n;
    logic [15:0] ma;

    always #5 clk = ~clk;

    gport_bridge #(.WAIT_CYC(WAIT_CYC)) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .mode(mode), .dir(dir),
        .hd_i(hd_i), .hd_o(hd_o), .hd_oe(hd_oe), .rdy(rdy),
        .ma(ma), .md_o(md_o), .md_i(md_i), .md_oe(md_oe), .mrw(mrw), .mcs_n(mcs_n)
    );

    function automatic logic [7:0] rv(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign md_i = (!mcs_n && mrw) ? memf(ma) : 8'h00;

    int checks = 0, fails = 0, memcnt = 0;
    logic [7:0]  expq[$];
    string       tagq[$];
    logic [15:0] last_wa = '0;
    logic [7:0]  last_wd = '0;
    logic        prev_oe = 1'b0, prev_rdy = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (hd_oe && !prev_oe) begin
            chk(prev_rdy == 1'b0, "R3 rdy fell one cycle earlier", prev_rdy, 0);
            if (expq.size() == 0) begin
                chk(1'b0, "R3 unexpected read data", hd_o, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(hd_o == e, t, hd_o, e);
            end
        end
        prev_oe  = hd_oe;
        prev_rdy = rdy;
        if (!mcs_n) memcnt++;
        if (!mcs_n && !mrw && md_oe) begin
            last_wa = ma;
            last_wd = md_o;
        end
    end

    // driver: one access; val is the logical byte written or expected
    task automatic acc(input bit m, input bit d, input logic [7:0] val, input string tag);
        int mc0, rc;
        mc0 = memcnt;
        rc  = 0;
        @(posedge clk); #1;
        sel_n = 1'b0; mode = m; dir = d;
        hd_i  = d ? 8'h00 : rv(val);
        if (d) begin
            expq.push_back(rv(val));
            tagq.push_back(tag);
        end
        repeat (WAIT_CYC + 3) begin
            @(negedge clk);
            if (rdy) rc++;
        end
        @(posedge clk); #1;
        sel_n = 1'b1;
        chk(rc == WAIT_CYC + 1, "R2 rdy high length", rc, WAIT_CYC + 1);
        chk((memcnt - mc0) == (m ? 0 : WAIT_CYC), m ? "R7 no memory on address access" : "R6 memory cycle length",
            memcnt - mc0, m ? 0 : WAIT_CYC);
    endtask

    task automatic set_addr(input logic [15:0] a);
        acc(1'b1, 1'b0, a[15:8], "R4");
        acc(1'b1, 1'b0, a[7:0], "R4");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!rdy && !hd_oe && mcs_n, "R2 reset state", {rdy, hd_oe, mcs_n}, 3'b001);

        acc(1, 1, 8'h00, "R10 reset address high");

        // R4 / R10
        set_addr(16'h1234);
        acc(1, 1, 8'h12, "R10 first address read");
        acc(1, 1, 8'h34, "R10 second address read");

        // R5
        set_addr(16'h0456);
        acc(0, 1, memf(16'h0456), "R5 data read");
        acc(0, 1, memf(16'h0457), "R5 data read after step");
        acc(1, 1, 8'h04, "R5 counter high");
        acc(1, 1, 8'h58, "R5 counter low");

        // R7 / R6 / R11
        set_addr(16'h0000);
        acc(1, 1, 8'h00, "R7 no step on address read");
        acc(1, 1, 8'h00, "R7 no step on address read");
        acc(0, 0, 8'h3C, "R6");
        chk(last_wa == 16'h0000, "R6 write address", last_wa, 16'h0000);
        chk(last_wd == 8'h3C, "R6 write data", last_wd, 8'h3C);
        acc(1, 1, 8'h00, "R7 high after write");
        acc(1, 1, 8'h01, "R7 low after write");
        acc(0, 0, 8'h80, "R11");
        chk(last_wd == 8'h80, "R11 host 0x01 to memory", last_wd, 8'h80);

        // R8
        set_addr(16'h3FFF);
        acc(0, 1, memf(16'h3FFF), "R8 read at top of bank");
        acc(0, 1, memf(16'h2000), "R8 read after wrap");
        acc(1, 1, 8'h20, "R8 bank kept");
        acc(1, 1, 8'h01, "R8 offset wrapped");

        // R9: counter now 0x0101
        acc(1, 0, 8'hAB, "R9 half load");
        acc(0, 1, memf(16'hAB01), "R9 data read after half load");
        set_addr(16'h2010);
        acc(1, 1, 8'h20, "R9 sequencer reset high");
        acc(1, 1, 8'h10, "R9 sequencer reset low");

        // R1
        set_addr(16'h1357);
        begin
            bit quiet;
            quiet = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(posedge clk); #1;
                mode = k[0]; dir = k[1]; hd_i = 8'(k * 37);
                @(negedge clk);
                if (hd_oe || !mcs_n || rdy) quiet = 1'b0;
            end
            chk(quiet, "R1 deselected port quiet", quiet, 1);
        end
        acc(1, 1, 8'h13, "R1 address unchanged high");
        acc(1, 1, 8'h57, "R1 address unchanged low");

        repeat (3) @(posedge clk);
        chk(expq.size() == 0, "R3 all reads seen", expq.size(), 0);
        finish_up();
    end
endmodule